// File: doc/BRIEF.md
# Partitioned Indirect Transfer Buffer

This block holds a single 32-bit wide on-chip memory shared by two transfer directions. The memory is split at a programmable word boundary. Words below the boundary form a receive region that collects bytes arriving from a serial flash engine. The block packs those bytes into words that a host then pulls out. Words at and above the boundary form a transmit region that the host fills with words. The block then unpacks them into a byte stream for the flash engine. Each region runs as its own circular queue, and its fill level in words can be read at any time.

A small register port configures each direction with a start address and a byte count, and issues start and cancel commands through a per-direction control register. The same register shows whether a transfer is in progress and whether it has finished. Counts need not be word multiples: the last word of a transfer carries only the remaining bytes, in its lowest byte lanes. Every edge of the block uses a ready/valid handshake, so a side that cannot proceed is held back and no data is dropped.

Top module: `xfer_sram_buf`

## Requirements
- R1: The buffer has 128 words. The partition register (offset 0, reset value 64) gives P, the number of words in the receive region; the transmit region gets 128-P words. Written values above 128 are stored as 128.
- R2: A partition write is ignored while either direction has a transfer in progress. An accepted partition write empties both regions.
- R3: The status register (offset 7) reports the receive-region level in bits 15:0 and the transmit-region level in bits 31:16, both counted in words.
- R4: Registers: offset 1 is receive control and offset 4 is transmit control. In each, bit 0 is start, bit 1 is cancel, bit 2 is in-progress and bit 5 is done. Offsets 2/3 hold the receive start address and byte count (16 bits); offsets 5/6 hold the same for transmit, and each start address is driven on its own output port. A start issued while that direction is in progress is ignored. An accepted start clears done.
- R5: During a receive transfer, flash bytes are accepted while the receive region is not full. Each group of four bytes is stored as one word, little-endian, with the first byte in bits 7:0. A final group of fewer than four bytes is stored with zero in the unused upper lanes.
- R6: During a transmit transfer, the host may write at most ceil(count/4) words, and only while the transmit region is not full. Bytes leave lowest lane first. Exactly count bytes are sent, so only the low lanes of a final partial word go out.
- R7: A receive transfer ends one cycle after its last byte is accepted: in-progress clears and done sets. A byte count of zero ends at once.
- R8: A transmit transfer ends only after all count bytes have been sent and the transmit region level is zero.
- R9: Done stays set until 1 is written to bit 5 of its control register. Writing 0 to bit 5 leaves it unchanged.
- R10: Cancel stops the transfer on the next edge. In-progress clears, done clears, that region is emptied, and that direction's flash handshake is deasserted. Cancel wins over a start in the same write.
- R11: Host reads stall (hrd_rdy low) while the receive region is empty. Host writes stall while the transmit region is full. Flash bytes stall while the receive region is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| hrd_req | input | 1 | Host pops a word from the receive region |
| hrd_rdy | output | 1 | Receive region holds at least one word |
| hrd_data | output | 32 | Oldest word of the receive region |
| hwr_req | input | 1 | Host pushes a word into the transmit region |
| hwr_rdy | output | 1 | Transmit region can take a word |
| hwr_data | input | 32 | Word pushed by the host |
| fin_valid | input | 1 | Flash engine offers a received byte |
| fin_ready | output | 1 | Block accepts the offered byte |
| fin_data | input | 8 | Received byte |
| fout_valid | output | 1 | Block offers a byte to transmit |
| fout_ready | input | 1 | Flash engine takes the byte |
| fout_data | output | 8 | Byte to transmit |
| rd_addr | output | 32 | Receive start address register |
| wr_addr | output | 32 | Transmit start address register |

## Verification
The states hardest to reach from the ports are full regions and a transmit transfer whose bytes are nearly all out while one word still sits in the buffer. Only a side that is held back can produce either state. Directed sequences therefore freeze one side of the handshake: the host does not pull while the flash side fills a small receive region, and the flash side does not pull while the host fills a small transmit region. Partition changes and cancels are then issued in that loaded state. Random traffic with random partitions, odd byte counts and random valid/ready throttling then covers wrap-around of both circular regions.

// File: rtl/xfer_sram_buf.sv
module xfer_sram_buf #(
  parameter int DEPTH = 128,
  parameter int CW    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        hrd_req,
  output logic        hrd_rdy,
  output logic [31:0] hrd_data,
  input  logic        hwr_req,
  output logic        hwr_rdy,
  input  logic [31:0] hwr_data,
  input  logic        fin_valid,
  output logic        fin_ready,
  input  logic [7:0]  fin_data,
  output logic        fout_valid,
  input  logic        fout_ready,
  output logic [7:0]  fout_data,
  output logic [31:0] rd_addr,
  output logic [31:0] wr_addr
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [LW-1:0] part, part_new, rd_lvl, wr_lvl;
  logic [PW-1:0] rd_wp, rd_rp, wr_wp, wr_rp, wr_base;
  logic          rd_busy, rd_done, wr_busy, wr_done;
  logic [CW-1:0] rd_cnt, wr_cnt, rd_rem, wr_rem, wr_need;
  logic [1:0]    rd_lane, wr_lane;
  logic [23:0]   acc;
  logic [31:0]   nw;

  function automatic logic [PW-1:0] rd_nxt(input logic [PW-1:0] p);
    return ({1'b0, p} + 1'b1 == part) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] wr_nxt(input logic [PW-1:0] p);
    return ({1'b0, p} + 1'b1 == FULL) ? part[PW-1:0] : p + 1'b1;
  endfunction

  wire rctl      = reg_wr && reg_addr == 3'd1;
  wire wctl      = reg_wr && reg_addr == 3'd4;
  wire rd_cancel = rctl && reg_wdata[1];
  wire wr_cancel = wctl && reg_wdata[1];
  wire rd_start  = rctl && reg_wdata[0] && !reg_wdata[1] && !rd_busy;
  wire wr_start  = wctl && reg_wdata[0] && !reg_wdata[1] && !wr_busy;
  wire part_wr   = reg_wr && reg_addr == 3'd0 && !rd_busy && !wr_busy;

  assign part_new = (reg_wdata > 32'(DEPTH)) ? FULL : reg_wdata[LW-1:0];
  assign wr_base  = part_wr ? part_new[PW-1:0] : part[PW-1:0];

  assign fin_ready = rd_busy && rd_rem != '0 && rd_lvl < part;
  wire   fin_go    = fin_valid && fin_ready;
  wire   commit    = fin_go && (rd_lane == 2'd3 || rd_rem == CW'(1));
  assign nw        = {8'h00, acc} | ({24'h0, fin_data} << {rd_lane, 3'b000});

  assign hrd_rdy  = rd_lvl != '0;
  assign hrd_data = mem[rd_rp];
  wire   hrd_go   = hrd_req && hrd_rdy;

  assign hwr_rdy    = wr_busy && wr_need != '0 && wr_lvl < FULL - part;
  wire   hwr_go     = hwr_req && hwr_rdy;
  assign fout_valid = wr_busy && wr_lvl != '0 && wr_rem != '0;
  assign fout_data  = mem[wr_rp][{wr_lane, 3'b000} +: 8];
  wire   fout_go    = fout_valid && fout_ready;
  wire   wpop       = fout_go && (wr_lane == 2'd3 || wr_rem == CW'(1));

  assign rd_addr = rd_addr_q;
  assign wr_addr = wr_addr_q;
  logic [31:0] rd_addr_q, wr_addr_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(part);
      3'd1:    reg_rdata = {26'h0, rd_done, 2'b00, rd_busy, 2'b00};
      3'd2:    reg_rdata = rd_addr_q;
      3'd3:    reg_rdata = 32'(rd_cnt);
      3'd4:    reg_rdata = {26'h0, wr_done, 2'b00, wr_busy, 2'b00};
      3'd5:    reg_rdata = wr_addr_q;
      3'd6:    reg_rdata = 32'(wr_cnt);
      default: reg_rdata = {16'(wr_lvl), 16'(rd_lvl)};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part      <= FULL >> 1;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: if (part_wr) part <= part_new;
        3'd2: rd_addr_q <= reg_wdata;
        3'd3: rd_cnt <= reg_wdata[CW-1:0];
        3'd5: wr_addr_q <= reg_wdata;
        3'd6: wr_cnt <= reg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[rd_wp] <= nw;
    if (hwr_go) mem[wr_wp] <= hwr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy <= 1'b0; rd_done <= 1'b0; rd_rem <= '0; rd_lane <= '0;
      acc <= '0; rd_wp <= '0; rd_rp <= '0; rd_lvl <= '0;
    end else begin
      rd_lvl <= rd_lvl + LW'(commit) - LW'(hrd_go);
      if (hrd_go) rd_rp <= rd_nxt(rd_rp);
      if (fin_go) begin
        rd_rem  <= rd_rem - 1'b1;
        rd_lane <= rd_lane + 1'b1;
        acc     <= nw[23:0];
      end
      if (commit) begin
        rd_wp   <= rd_nxt(rd_wp);
        rd_lane <= '0;
        acc     <= '0;
      end
      if (rctl && reg_wdata[5]) rd_done <= 1'b0;
      if (rd_busy && rd_rem == '0) begin
        rd_busy <= 1'b0;
        rd_done <= 1'b1;
      end
      if (rd_start) begin
        rd_busy <= 1'b1; rd_done <= 1'b0; rd_rem <= rd_cnt;
        rd_lane <= '0;   acc <= '0;
      end
      if (rd_cancel || part_wr) begin
        rd_wp <= '0; rd_rp <= '0; rd_lvl <= '0; rd_lane <= '0; acc <= '0;
      end
      if (rd_cancel) begin
        rd_busy <= 1'b0;
        rd_done <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_busy <= 1'b0; wr_done <= 1'b0; wr_rem <= '0; wr_need <= '0;
      wr_lane <= '0; wr_wp <= PW'(DEPTH / 2); wr_rp <= PW'(DEPTH / 2); wr_lvl <= '0;
    end else begin
      wr_lvl <= wr_lvl + LW'(hwr_go) - LW'(wpop);
      if (hwr_go) begin
        wr_wp   <= wr_nxt(wr_wp);
        wr_need <= wr_need - 1'b1;
      end
      if (fout_go) begin
        wr_rem  <= wr_rem - 1'b1;
        wr_lane <= wr_lane + 1'b1;
      end
      if (wpop) begin
        wr_rp   <= wr_nxt(wr_rp);
        wr_lane <= '0;
      end
      if (wctl && reg_wdata[5]) wr_done <= 1'b0;
      if (wr_busy && wr_rem == '0 && wr_lvl == '0) begin
        wr_busy <= 1'b0;
        wr_done <= 1'b1;
      end
      if (wr_start) begin
        wr_busy <= 1'b1; wr_done <= 1'b0; wr_rem <= wr_cnt; wr_lane <= '0;
        wr_need <= CW'(({1'b0, wr_cnt} + (CW+1)'(3)) >> 2);
      end
      if (wr_cancel || part_wr) begin
        wr_wp <= wr_base; wr_rp <= wr_base; wr_lvl <= '0; wr_lane <= '0; wr_need <= '0;
      end
      if (wr_cancel) begin
        wr_busy <= 1'b0;
        wr_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfer_sram_buf_chk.sv
module xfer_sram_buf_chk #(
  parameter int DEPTH = 128
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [2:0]               reg_addr,
  input logic [31:0]              reg_wdata,
  input logic                     rd_busy,
  input logic                     rd_done,
  input logic                     wr_busy,
  input logic                     wr_done,
  input logic [$clog2(DEPTH):0]   rd_lvl,
  input logic [$clog2(DEPTH):0]   wr_lvl,
  input logic [$clog2(DEPTH):0]   part,
  input logic                     fin_ready
);
  localparam int LW = $clog2(DEPTH) + 1;

  a_r1_rd_cap: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lvl <= part);
  a_r1_wr_cap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lvl <= LW'(DEPTH) - part);
  a_r2_part_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy || wr_busy) |=> part == $past(part));
  a_r4_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_busy && rd_done));
  a_r4_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_busy && wr_done));
  a_r8_drained: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_done) |-> wr_lvl == '0);
  a_r10_rd_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[1]) |=> (!rd_busy && !rd_done && rd_lvl == '0));
  a_r10_wr_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && reg_wdata[1]) |=> (!wr_busy && !wr_done && wr_lvl == '0));
  a_r11_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lvl == part) |-> !fin_ready);
endmodule

bind xfer_sram_buf xfer_sram_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rd_busy(rd_busy), .rd_done(rd_done), .wr_busy(wr_busy), .wr_done(wr_done),
  .rd_lvl(rd_lvl), .wr_lvl(wr_lvl), .part(part), .fin_ready(fin_ready)
);

// File: tb/tb_xfer_sram_buf.sv
`timescale 1ns/1ps
module tb_xfer_sram_buf;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        hrd_req = 1'b0, hrd_rdy;
  logic [31:0] hrd_data;
  logic        hwr_req = 1'b0, hwr_rdy;
  logic [31:0] hwr_data = '0;
  logic        fin_valid = 1'b0, fin_ready;
  logic [7:0]  fin_data = '0;
  logic        fout_valid, fout_ready = 1'b0;
  logic [7:0]  fout_data;
  logic [31:0] rd_addr, wr_addr;

  xfer_sram_buf dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int ri = 0, wi = 0, bi = 0;
  logic [7:0]  src [0:1023];
  logic [31:0] hw  [0:255];

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string req);
    reg_addr = a; #1;
    chk_eq(req, reg_rdata, exp);
  endtask

  function automatic logic [31:0] exp_word(input int w, input int n);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (4*w + k < n) v[8*k +: 8] = src[4*w + k];
    return v;
  endfunction

  task automatic feed(input int k);
    int j = 0;
    while (j < k) begin
      @(negedge clk); fin_valid = 1'b1; fin_data = src[ri]; #1;
      if (fin_ready) begin ri++; j++; end
    end
    @(negedge clk); fin_valid = 1'b0;
  endtask

  task automatic push(input int k);
    int j = 0;
    while (j < k) begin
      @(negedge clk); hwr_req = 1'b1; hwr_data = hw[wi]; #1;
      if (hwr_rdy) begin wi++; j++; end
    end
    @(negedge clk); hwr_req = 1'b0;
  endtask

  task automatic pull(input int k);
    int j = 0;
    while (j < k) begin
      @(negedge clk); fout_ready = 1'b1; #1;
      if (fout_valid) begin
        chk_eq("R6 byte order", fout_data, hw[bi/4][8*(bi%4) +: 8]);
        bi++; j++;
      end
    end
    @(negedge clk); fout_ready = 1'b0;
  endtask

  task automatic run_read(input int n, input int vp, input int rp, input logic [31:0] a);
    for (int i = 0; i < n; i++) src[i] = 8'($urandom);
    ri = 0;
    wr_reg(3'd3, n); wr_reg(3'd2, a); wr_reg(3'd1, 32'h1);
    chk_eq("R4 read address port", rd_addr, a);
    fork
      begin
        while (ri < n) begin
          @(negedge clk); fin_valid = ($urandom % 100) < vp; fin_data = src[ri]; #1;
          if (fin_valid && fin_ready) ri++;
        end
        @(negedge clk); fin_valid = 1'b0;
      end
      begin
        int w = 0;
        while (w < (n + 3) / 4) begin
          @(negedge clk); hrd_req = ($urandom % 100) < rp; #1;
          if (hrd_req && hrd_rdy) begin
            chk_eq("R5 packed word", hrd_data, exp_word(w, n));
            w++;
          end
        end
        @(negedge clk); hrd_req = 1'b0;
      end
    join
    repeat (2) @(negedge clk);
    expect_reg(3'd1, 32'h20, "R7 receive done");
    expect_reg(3'd7, 32'h0, "R3 levels empty after receive");
  endtask

  task automatic run_write(input int n, input int vp, input int rp, input logic [31:0] a);
    for (int i = 0; i < (n + 3) / 4; i++) hw[i] = $urandom;
    wr_reg(3'd6, n); wr_reg(3'd5, a); wr_reg(3'd4, 32'h1);
    chk_eq("R4 write address port", wr_addr, a);
    fork
      begin
        int w = 0;
        while (w < (n + 3) / 4) begin
          @(negedge clk); hwr_req = ($urandom % 100) < vp; hwr_data = hw[w]; #1;
          if (hwr_req && hwr_rdy) w++;
        end
        @(negedge clk); hwr_req = 1'b0;
      end
      begin
        int b = 0;
        while (b < n) begin
          @(negedge clk); fout_ready = ($urandom % 100) < rp; #1;
          if (fout_ready && fout_valid) begin
            chk_eq("R6 byte order", fout_data, hw[b/4][8*(b%4) +: 8]);
            b++;
          end
        end
        @(negedge clk); fout_ready = 1'b0;
      end
    join
    repeat (2) @(negedge clk);
    chk_eq("R6 no extra byte", fout_valid, 1'b0);
    expect_reg(3'd4, 32'h20, "R8 transmit done");
    expect_reg(3'd7, 32'h0, "R3 levels empty after transmit");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg(3'd0, 32'd64, "R1 partition reset");
    expect_reg(3'd1, 32'h0, "R4 receive control reset");
    expect_reg(3'd4, 32'h0, "R4 transmit control reset");
    expect_reg(3'd7, 32'h0, "R3 status reset");
    chk_eq("R11 host read stalls when empty", hrd_rdy, 1'b0);
    chk_eq("R11 host write stalls when idle", hwr_rdy, 1'b0);

    wr_reg(3'd0, 32'd200);
    expect_reg(3'd0, 32'd128, "R1 partition clamp");
    wr_reg(3'd0, 32'd64);

    run_read(13, 70, 60, 32'h0000_1000);
    run_read(4, 100, 100, 32'h0000_2000);
    run_read(1, 50, 50, 32'h0000_3003);

    wr_reg(3'd1, 32'h0);
    expect_reg(3'd1, 32'h20, "R9 zero write keeps done");
    wr_reg(3'd1, 32'h20);
    expect_reg(3'd1, 32'h0, "R9 write one clears done");

    wr_reg(3'd3, 32'd0); wr_reg(3'd1, 32'h1);
    @(negedge clk);
    expect_reg(3'd1, 32'h20, "R7 zero count ends at once");

    wr_reg(3'd0, 32'd4);
    for (int i = 0; i < 32; i++) src[i] = 8'($urandom);
    ri = 0;
    wr_reg(3'd3, 32'd32); wr_reg(3'd1, 32'h1);
    feed(16);
    chk_eq("R11 flash stalls when receive region full", fin_ready, 1'b0);
    expect_reg(3'd7, 32'd4, "R3 receive level");
    wr_reg(3'd0, 32'd10);
    expect_reg(3'd0, 32'd4, "R2 partition locked while busy");
    wr_reg(3'd1, 32'h3);
    expect_reg(3'd1, 32'h0, "R10 receive cancel control");
    expect_reg(3'd7, 32'h0, "R10 receive region flushed");
    chk_eq("R10 host read blocked after cancel", hrd_rdy, 1'b0);
    chk_eq("R10 flash handshake off after cancel", fin_ready, 1'b0);

    wr_reg(3'd0, 32'd64);
    for (int i = 0; i < 8; i++) src[i] = 8'($urandom);
    ri = 0;
    wr_reg(3'd3, 32'd8); wr_reg(3'd1, 32'h1);
    feed(4);
    wr_reg(3'd1, 32'h1);
    feed(4);
    @(negedge clk);
    expect_reg(3'd1, 32'h20, "R4 start ignored while busy");
    expect_reg(3'd7, 32'd2, "R4 receive level after restart attempt");
    wr_reg(3'd0, 32'd64);
    expect_reg(3'd7, 32'd0, "R2 partition write empties regions");

    run_write(13, 70, 60, 32'h0001_0000);
    run_write(4, 100, 100, 32'h0002_0000);
    run_write(1, 50, 50, 32'h0003_0001);

    wr_reg(3'd0, 32'd124);
    for (int i = 0; i < 16; i++) hw[i] = $urandom;
    wi = 0;
    wr_reg(3'd6, 32'd64); wr_reg(3'd4, 32'h1);
    push(4);
    chk_eq("R11 host write stalls when transmit region full", hwr_rdy, 1'b0);
    expect_reg(3'd7, 32'd4 << 16, "R3 transmit level");
    chk_eq("R6 byte offered while loaded", fout_valid, 1'b1);
    wr_reg(3'd0, 32'd8);
    expect_reg(3'd0, 32'd124, "R2 partition locked during transmit");
    wr_reg(3'd4, 32'h2);
    expect_reg(3'd4, 32'h0, "R10 transmit cancel control");
    expect_reg(3'd7, 32'h0, "R10 transmit region flushed");
    chk_eq("R10 flash handshake off after transmit cancel", fout_valid, 1'b0);

    wr_reg(3'd0, 32'd64);
    for (int i = 0; i < 2; i++) hw[i] = $urandom;
    wi = 0; bi = 0;
    wr_reg(3'd6, 32'd5); wr_reg(3'd4, 32'h1);
    push(2);
    chk_eq("R6 host word limit", hwr_rdy, 1'b0);
    pull(4);
    @(negedge clk);
    expect_reg(3'd4, 32'h4, "R8 not done before drain");
    expect_reg(3'd7, 32'd1 << 16, "R8 one word left");
    pull(1);
    @(negedge clk);
    expect_reg(3'd4, 32'h20, "R8 done after drain");
    expect_reg(3'd7, 32'h0, "R8 region empty");

    for (int it = 0; it < 16; it++) begin
      int p = 8 + int'($urandom % 113);
      int n = 1 + int'($urandom % 200);
      wr_reg(3'd0, p);
      expect_reg(3'd0, p, "R1 partition write");
      if (it % 2 == 1) run_read(n, 30 + int'($urandom % 71), 30 + int'($urandom % 71), $urandom);
      else run_write(n, 30 + int'($urandom % 71), 30 + int'($urandom % 71), $urandom);
    end

    if (seed == -1) $display("seed %0d", seed);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule